// File: doc/BRIEF.md
# Two-Pin Open-Drain I/O Channel with Filtered Activity Capture

This block controls two general-purpose open-drain pins. Each pin has an output latch that sets the level the block drives. A shared pulse sequencer can invert selected pins for a fixed number of microsecond ticks. Each pin also has a sensed input path. That path has a two-stage synchronizer and a glitch filter, and it feeds a sticky activity flag that records every accepted change of level.

At reset, both output latches take the level of a polarity strap input. The pulse sequencer accepts a request only while external supply is reported present. A match output summarises the pins for a conditional search. Per pin, it tests either the sensed level against a chosen polarity or the activity flag, and it ORs the enabled pins together. Register decoding and the serial bus protocol sit outside this block: they drive the write, pulse and clear strobes directly.

Top module: `pio_channel`

## Requirements
- R1: `pinPullDn[i]` is 1 exactly when the driven level of pin i is 0. The driven level is the output latch bit XOR the pulse-active bit of that pin.
- R2: While `rst_n` is low, and on the first cycle after it rises, both latch bits equal `polStrap`, no pulse is active and both activity flags are 0.
- R3: A cycle with `outWrEn` high loads `outWrData` into the latch. The new value shows on `pinPullDn` after that clock edge.
- R4: `pinIn` passes through a two-flop synchronizer. `pinLevel[i]` takes a new synchronized value only after that value has differed from `pinLevel[i]` on FILT_TICKS consecutive `usTick` cycles. A shorter excursion leaves `pinLevel` unchanged.
- R5: `actFlag[i]` goes to 1 on the edge at which `pinLevel[i]` changes. It stays 1 until an edge with `actClr` high. If a change and a clear fall on the same edge, the flag is 1.
- R6: `pulseStart` with `supplyOk` high, no pulse active and nonzero `pulseSel` inverts the pins selected by `pulseSel` (bit i selects pin i). The inversion begins after that edge, lasts exactly PULSE_TICKS `usTick` cycles, and then the pins return to their latch level.
- R7: `pulseStart` while `supplyOk` is low starts no pulse.
- R8: `pulseStart` while a pulse is active changes neither the pins being pulsed nor the remaining length of the pulse.
- R9: `condMatch` is the OR over pins of `condMask[i]` AND a per-pin hit. With `condSrc`=0 the hit is `pinLevel[i]==condPol[i]`. With `condSrc`=1 the hit is `actFlag[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| polStrap | input | 1 | Power-up level for both output latches |
| supplyOk | input | 1 | External supply present; enables the pulse function |
| usTick | input | 1 | One-cycle microsecond tick |
| pinIn | input | 2 | Pin levels as seen at the pads |
| outWrEn | input | 1 | Output latch write strobe |
| outWrData | input | 2 | New output latch value |
| pulseStart | input | 1 | Pulse request strobe |
| pulseSel | input | 2 | Pins to pulse |
| actClr | input | 1 | Clears both activity flags |
| condMask | input | 2 | Pins taking part in the match |
| condPol | input | 2 | Level sought per pin when matching on level |
| condSrc | input | 1 | 0: match on level, 1: match on activity |
| pinPullDn | output | 2 | Pull-down enable per pin |
| pinLevel | output | 2 | Filtered pin level |
| actFlag | output | 2 | Sticky activity flags |
| condMatch | output | 1 | Conditional search match |

## Verification
A corrupted output latch or pulse sequencer state shows on `pinPullDn` in the very next cycle. A pulse of the wrong length shows within one tick of the point where it should have ended. A filter counter that is off by one moves the edge of `pinLevel` by one tick, so that edge is compared cycle by cycle after the two synchronizer stages. A lost or spurious activity flag appears on `actFlag` one cycle after the filter accepts a change. It also appears on `condMatch` in the same cycle whenever activity matching is selected.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_W = 2;

  typedef struct packed {
    logic             latchWr;
    logic [PIO_W-1:0] latchData;
    logic [PIO_W-1:0] pulseOn;
    logic             actClr;
  } pio_strb_t;
endpackage

// File: rtl/pio_filter.sv
module pio_filter #(
  parameter int unsigned FILT_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rawIn,
  input  logic actClr,
  output logic level,
  output logic act
);
  localparam int unsigned CNT_W = (FILT_TICKS > 1) ? $clog2(FILT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_TICKS - 1);
  localparam int unsigned MIS_W = $clog2(FILT_TICKS + 1);
  localparam logic [MIS_W-1:0] MIS_MAX = MIS_W'(FILT_TICKS);

  logic syncA, syncB, filt, actQ;
  logic [CNT_W-1:0] cnt;
  logic accept;

  assign accept = (syncB != filt) && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    syncA <= rawIn;
    syncB <= syncA;
    if (!rst_n) begin
      filt <= syncB;
      cnt  <= '0;
      actQ <= 1'b0;
    end else begin
      if (syncB == filt) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          filt <= syncB;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (accept)      actQ <= 1'b1;
      else if (actClr) actQ <= 1'b0;
    end
  end

  assign level = filt;
  assign act   = actQ;

  // Independent count of mismatched cycles, used only by the check below.
  logic [MIS_W-1:0] misCyc;
  always_ff @(posedge clk) begin
    if (!rst_n || syncB == filt) misCyc <= '0;
    else if (misCyc != MIS_MAX)  misCyc <= misCyc + 1'b1;
  end

  // R4: an accepted change was preceded by enough mismatched cycles
  p_filter_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(filt)) |-> ($past(misCyc) >= MIS_W'(FILT_TICKS - 1)));

  // R5: activity holds until cleared
  p_act_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (actQ && !actClr) |=> actQ);
endmodule

// File: rtl/pio_control.sv
module pio_control
  import pio_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supplyOk,
  input  logic             usTick,
  input  logic             outWrEn,
  input  logic [PIO_W-1:0] outWrData,
  input  logic             pulseStart,
  input  logic [PIO_W-1:0] pulseSel,
  input  logic             actClr,
  output pio_strb_t        strb
);
  localparam int unsigned PC_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [PC_W-1:0] PLAST = PC_W'(PULSE_TICKS - 1);

  logic [PIO_W-1:0] run;
  logic [PC_W-1:0]  pcnt;
  logic             startOk;
  logic             busy;

  assign busy    = |run;
  assign startOk = pulseStart && supplyOk && !busy && (|pulseSel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      pcnt <= '0;
    end else if (startOk) begin
      run  <= pulseSel;
      pcnt <= '0;
    end else if (busy && usTick) begin
      if (pcnt == PLAST) begin
        run  <= '0;
        pcnt <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.latchWr   = outWrEn;
    strb.latchData = outWrData;
    strb.pulseOn   = run;
    strb.actClr    = actClr;
  end

  // R7: without supply an idle sequencer stays idle
  p_nosupply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !supplyOk) |=> (run == '0));

  // R8: a running pulse keeps its pin set until its last tick
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(usTick && pcnt == PLAST)) |=> (run == $past(run)));
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int unsigned FILT_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             polStrap,
  input  logic             usTick,
  input  logic [PIO_W-1:0] pinIn,
  input  pio_strb_t        strb,
  input  logic [PIO_W-1:0] condMask,
  input  logic [PIO_W-1:0] condPol,
  input  logic             condSrc,
  output logic [PIO_W-1:0] pinPullDn,
  output logic [PIO_W-1:0] pinLevel,
  output logic [PIO_W-1:0] actFlag,
  output logic             condMatch
);
  logic [PIO_W-1:0] outLatch;
  logic [PIO_W-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n)            outLatch <= {PIO_W{polStrap}};
    else if (strb.latchWr) outLatch <= strb.latchData;
  end

  assign pinPullDn = ~(outLatch ^ strb.pulseOn);

  for (genvar i = 0; i < PIO_W; i++) begin : g_pin
    pio_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (usTick),
      .rawIn  (pinIn[i]),
      .actClr (strb.actClr),
      .level  (pinLevel[i]),
      .act    (actFlag[i])
    );
    assign hit[i] = condMask[i] & (condSrc ? actFlag[i] : (pinLevel[i] == condPol[i]));
  end

  assign condMatch = |hit;

  // R2: first cycle after reset shows the strap level in the latch
  p_strap_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (outLatch == {PIO_W{$past(polStrap)}}));
endmodule

// File: rtl/pio_channel.sv
module pio_channel
  import pio_pkg::*;
#(
  parameter int unsigned FILT_TICKS  = 10,
  parameter int unsigned PULSE_TICKS = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             polStrap,
  input  logic             supplyOk,
  input  logic             usTick,
  input  logic [PIO_W-1:0] pinIn,
  input  logic             outWrEn,
  input  logic [PIO_W-1:0] outWrData,
  input  logic             pulseStart,
  input  logic [PIO_W-1:0] pulseSel,
  input  logic             actClr,
  input  logic [PIO_W-1:0] condMask,
  input  logic [PIO_W-1:0] condPol,
  input  logic             condSrc,
  output logic [PIO_W-1:0] pinPullDn,
  output logic [PIO_W-1:0] pinLevel,
  output logic [PIO_W-1:0] actFlag,
  output logic             condMatch
);
  pio_strb_t strb;

  pio_control #(.PULSE_TICKS(PULSE_TICKS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .supplyOk   (supplyOk),
    .usTick     (usTick),
    .outWrEn    (outWrEn),
    .outWrData  (outWrData),
    .pulseStart (pulseStart),
    .pulseSel   (pulseSel),
    .actClr     (actClr),
    .strb       (strb)
  );

  pio_datapath #(.FILT_TICKS(FILT_TICKS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .polStrap  (polStrap),
    .usTick    (usTick),
    .pinIn     (pinIn),
    .strb      (strb),
    .condMask  (condMask),
    .condPol   (condPol),
    .condSrc   (condSrc),
    .pinPullDn (pinPullDn),
    .pinLevel  (pinLevel),
    .actFlag   (actFlag),
    .condMatch (condMatch)
  );
endmodule

// File: tb/pio_channel_test.sv
module pio_channel_test;
  localparam int FT = 10;
  localparam int PT = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic polStrap = 1'b1, supplyOk = 1'b1, usTick = 1'b1;
  logic [1:0] pinIn = 2'b11, outWrData = 2'b00, pulseSel = 2'b00;
  logic outWrEn = 1'b0, pulseStart = 1'b0, actClr = 1'b0;
  logic [1:0] condMask = 2'b00, condPol = 2'b00;
  logic condSrc = 1'b0;
  logic [1:0] pinPullDn, pinLevel, actFlag;
  logic condMatch;

  int nChecks = 0, nFails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pio_channel #(.FILT_TICKS(FT), .PULSE_TICKS(PT)) uut (
    .clk(clk), .rst_n(rst_n), .polStrap(polStrap), .supplyOk(supplyOk),
    .usTick(usTick), .pinIn(pinIn), .outWrEn(outWrEn), .outWrData(outWrData),
    .pulseStart(pulseStart), .pulseSel(pulseSel), .actClr(actClr),
    .condMask(condMask), .condPol(condPol), .condSrc(condSrc),
    .pinPullDn(pinPullDn), .pinLevel(pinLevel), .actFlag(actFlag),
    .condMatch(condMatch));

  // Reference model built from the requirements
  logic [1:0] mS1, mS2, mFilt, mAct, mLatch, mRun;
  int mCnt [2];
  int mPc;

  always @(posedge clk) begin
    mS1 <= pinIn;
    mS2 <= mS1;
    if (!rst_n) begin
      mFilt <= mS2; mAct <= 2'b00; mLatch <= {2{polStrap}};
      mRun <= 2'b00; mPc <= 0; mCnt[0] <= 0; mCnt[1] <= 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (mS2[i] == mFilt[i]) mCnt[i] <= 0;
        else if (usTick) begin
          if (mCnt[i] == FT-1) begin
            mFilt[i] <= mS2[i]; mCnt[i] <= 0; mAct[i] <= 1'b1;
          end else mCnt[i] <= mCnt[i] + 1;
        end
        if (actClr && !(mS2[i] != mFilt[i] && usTick && mCnt[i] == FT-1))
          mAct[i] <= 1'b0;
      end
      if (outWrEn) mLatch <= outWrData;
      if (pulseStart && supplyOk && mRun == 2'b00 && pulseSel != 2'b00) begin
        mRun <= pulseSel; mPc <= 0;
      end else if (mRun != 2'b00 && usTick) begin
        if (mPc == PT-1) begin mRun <= 2'b00; mPc <= 0; end
        else mPc <= mPc + 1;
      end
    end
  end

  function automatic logic expMatch(logic [1:0] lvl, logic [1:0] act,
                                    logic [1:0] msk, logic [1:0] pol, logic src);
    return src ? |(msk & act) : |(msk & ~(lvl ^ pol));
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int actual, input int expected);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, actual, expected, cyc);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // One cycle: wait for the falling edge, compare against the model
  task automatic step();
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      chk(pinPullDn == ~(mLatch ^ mRun), "R1/R6", "pinPullDn", pinPullDn, ~(mLatch ^ mRun));
      chk(pinLevel == mFilt, "R4", "pinLevel", pinLevel, mFilt);
      chk(actFlag == mAct, "R5", "actFlag", actFlag, mAct);
      chk(condMatch == expMatch(mFilt, mAct, condMask, condPol, condSrc), "R9", "condMatch",
          condMatch, expMatch(mFilt, mAct, condMask, condPol, condSrc));
    end
  endtask

  task automatic idle();
    outWrEn = 1'b0; pulseStart = 1'b0; actClr = 1'b0;
  endtask

  task automatic doReset(input logic strap);
    rst_n = 1'b0; polStrap = strap; idle();
    for (int k = 0; k < 5; k++) step();
    chk(pinPullDn == ~{2{strap}}, "R2", "pullDn in reset", pinPullDn, ~{2{strap}});
    chk(actFlag == 2'b00, "R2", "actFlag in reset", actFlag, 0);
    rst_n = 1'b1;
    step();
    chk(pinPullDn == ~{2{strap}}, "R2", "pullDn after reset", pinPullDn, ~{2{strap}});
    chk(actFlag == 2'b00, "R2", "actFlag after reset", actFlag, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : main
    int hi;
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset(1'b1);

    // R3 / R1: latch write
    outWrEn = 1'b1; outWrData = 2'b01; step(); idle();
    chk(pinPullDn == 2'b10, "R3", "latch write", pinPullDn, 2'b10);

    // R4: 9-tick excursion is rejected
    pinIn = 2'b10;
    for (int k = 0; k < FT-1; k++) step();
    pinIn = 2'b11;
    for (int k = 0; k < 20; k++) step();
    chk(pinLevel == 2'b11, "R4", "short glitch rejected", pinLevel, 2'b11);
    chk(actFlag == 2'b00, "R5", "no activity on glitch", actFlag, 0);

    // R4 / R5: long change accepted and latched
    pinIn = 2'b10;
    for (int k = 0; k < 30; k++) step();
    chk(pinLevel == 2'b10, "R4", "long change accepted", pinLevel, 2'b10);
    chk(actFlag == 2'b01, "R5", "activity set", actFlag, 2'b01);
    condMask = 2'b01; condSrc = 1'b1; step();
    chk(condMatch == 1'b1, "R9", "match on activity", condMatch, 1);
    actClr = 1'b1; step(); idle(); step();
    chk(actFlag == 2'b00, "R5", "activity cleared", actFlag, 0);

    // R7: no supply, no pulse
    supplyOk = 1'b0; pulseStart = 1'b1; pulseSel = 2'b11; step(); idle();
    for (int k = 0; k < 5; k++) step();
    chk(pinPullDn == 2'b10, "R7", "pulse without supply", pinPullDn, 2'b10);

    // R6 / R8: timed pulse on pin 0, second request ignored
    supplyOk = 1'b1; pulseStart = 1'b1; pulseSel = 2'b01; step(); idle();
    hi = 0;
    for (int k = 0; k < 2*PT; k++) begin
      if (pinPullDn[0]) hi++;
      if (k == 3) begin pulseStart = 1'b1; pulseSel = 2'b10; end
      if (k == 4) begin
        idle();
        chk(pinPullDn[1] == 1'b1, "R8", "second request ignored", pinPullDn[1], 1);
      end
      step();
    end
    chk(hi == PT, "R6", "pulse length", hi, PT);
    chk(pinPullDn == 2'b10, "R6", "returned to latch", pinPullDn, 2'b10);

    // Random phase
    for (int k = 0; k < 6000; k++) begin
      idle();
      usTick = ($urandom % 2) == 0;
      for (int i = 0; i < 2; i++) if ($urandom % 48 == 0) pinIn[i] = ~pinIn[i];
      if ($urandom % 25 == 0) begin outWrEn = 1'b1; outWrData = 2'($urandom); end
      if ($urandom % 40 == 0) begin pulseStart = 1'b1; pulseSel = 2'($urandom); end
      if ($urandom % 30 == 0) actClr = 1'b1;
      if ($urandom % 90 == 0) supplyOk = ~supplyOk;
      if ($urandom % 16 == 0) begin
        condMask = 2'($urandom); condPol = 2'($urandom); condSrc = 1'($urandom);
      end
      step();
    end

    // R2 with the other strap level
    usTick = 1'b1; pinIn = 2'b01;
    doReset(1'b0);
    for (int k = 0; k < 20; k++) step();
    summary();
  end
endmodule